// File: doc/BRIEF.md
# CPU Request Priority Sequencer

This block is the request-arbitration front end of a small 8-bit processor core. It watches the active-low request lines: one external bus request, one non-maskable interrupt and three maskable interrupts. It also watches an active-low wait line. Two strobes from the sequencing logic mark where a machine cycle ends and where an instruction ends. From these inputs the block decides which request wins and at which boundary it may be taken. A bus request can be taken at any machine-cycle boundary. Interrupts are taken only where an instruction ends.

When the bus is granted, the block drives bus-acknowledge low and drops an enable that the pad logic uses to float the address bus, the data bus and the memory/IO strobes. When an interrupt is accepted, the block emits a one-cycle acknowledge pulse with a source code. The instruction fetch and I/O strobes are pulsed low only for the lowest-numbered maskable line. The block holds the interrupt-enable flag and a copy of it saved on NMI entry. It also tracks whether the core is halted after a halt or sleep instruction, and it wakes the core on an accepted interrupt.

Top module: `req_priority_seq`

## Requirements
- R1: Priority at a shared boundary is: bus request, then a pending NMI, then maskable line 0, then line 1, then line 2. A lower-numbered maskable line beats a higher one.
- R2: A low `busReqN` is granted at a clock edge where the core is not granted and the core is at a machine-cycle boundary. Such a boundary is `mcEnd` or `insEnd` high with `waitN` high, or any cycle while halted. In the cycle after that edge, `busAckN` is 0 and `busOe` is 0. On the first edge that sees `busReqN` high while granted, both return to 1 in the following cycle.
- R3: An interrupt is accepted only at an instruction boundary. Such a boundary is `insEnd` high with `waitN` high, or any cycle while halted. A request present only at `mcEnd`, or at no boundary at all, is not taken.
- R4: A maskable line is taken only while `ieFlag` is 1. An NMI is taken whatever `ieFlag` is. Any acceptance clears `ieFlag`. NMI acceptance saves the old flag, and `nmiRet` restores it. In precedence order, `ieSet` sets the flag and `ieClr` clears it.
- R5: An acceptance gives `ackValid`=1 for exactly one cycle. `ackSrc` is 0 for NMI and k+1 for maskable line k, and it holds its value afterwards. `ackM1N` and `ackIorqN` are 0 in that cycle only when the source is line 0 (code 1).
- R6: An `insEnd` at a boundary with `haltIns`=1 and nothing accepted drives `haltN` to 0. `haltN` returns to 1 only in the cycle of an acceptance. A bus grant taken while halted leaves the core halted after release.
- R7: While `waitN` is 0, `mcEnd` and `insEnd` are ignored, so nothing is granted or accepted. `waitStall` then equals 1 combinationally, as long as the bus is not granted.
- R8: The NMI is edge-sensitive. A fall of `nmiN` makes one request. A line held low is not taken again.
- R9: After reset: `busAckN`=1, `busOe`=1, `haltN`=1, `ackValid`=0, `ackSrc`=0, `ackM1N`=1, `ackIorqN`=1, `ieFlag`=0.
- R10: While granted, no interrupt is accepted and the boundary strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReqN | input | 1 | External bus request, active low |
| nmiN | input | 1 | Non-maskable interrupt, active low, edge-sensitive |
| mintN | input | 3 | Maskable interrupt lines, active low, bit 0 highest priority |
| waitN | input | 1 | Wait request, active low |
| mcEnd | input | 1 | Machine-cycle end strobe |
| insEnd | input | 1 | Instruction end strobe |
| haltIns | input | 1 | Ending instruction is a halt or sleep |
| ieSet | input | 1 | Set the interrupt-enable flag |
| ieClr | input | 1 | Clear the interrupt-enable flag |
| nmiRet | input | 1 | Return from NMI: restore saved enable |
| busAckN | output | 1 | Bus acknowledge, active low |
| busOe | output | 1 | Bus driver enable, 0 while granted |
| haltN | output | 1 | Halt status, active low |
| waitStall | output | 1 | Core stalled by wait |
| ackValid | output | 1 | Interrupt acknowledge pulse |
| ackSrc | output | 2 | Acknowledged source code |
| ackM1N | output | 1 | Fetch strobe of the acknowledge cycle, active low |
| ackIorqN | output | 1 | I/O strobe of the acknowledge cycle, active low |
| ieFlag | output | 1 | Interrupt-enable flag |

## Verification
A wrong internal state shows up at the ports within one cycle of the next boundary that uses it.

- A grant-state error shows on `busAckN` and `busOe` right after the edge. It also shows as a missing or spurious acknowledge while the core should be frozen.
- A stale pending NMI, or a wrong enable flag, shows as an `ackValid` pulse with the wrong `ackSrc` at the next instruction boundary. The same fault shows as a missing clear of `ieFlag`.
- A lost halt state shows on `haltN` at once. The stimulus therefore puts two requests at each boundary, grants the bus while halted, and places requests in wait cycles, so that each fault reaches an output.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int MINT_N = 3;
  localparam int SRC_W  = $clog2(MINT_N + 1);

  typedef enum logic {BUS_IDLE = 1'b0, BUS_GRANT = 1'b1} busState_t;

  typedef struct packed {
    logic             take;
    logic [SRC_W-1:0] src;
    logic             haltGo;
  } ctlStrobe_t;
endpackage

// File: rtl/rps_ctrl.sv
module rps_ctrl
  import rps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReqN,
  input  logic [MINT_N-1:0] mintN,
  input  logic              waitN,
  input  logic              mcEnd,
  input  logic              insEnd,
  input  logic              haltIns,
  input  logic              ieFlag,
  input  logic              nmiPend,
  input  logic              halted,
  output ctlStrobe_t        strobe,
  output logic              busAckN,
  output logic              busOe,
  output logic              waitStall
);
  busState_t state;
  logic idle, mcBound, insBound, busWin;
  logic pickValid;
  logic [SRC_W-1:0] pickSrc;

  assign idle     = (state == BUS_IDLE);
  assign mcBound  = ((mcEnd | insEnd) & waitN) | halted;
  assign insBound = (insEnd & waitN) | halted;
  assign busWin   = idle & ~busReqN & mcBound;

  // pending NMI first, then the lowest-numbered enabled maskable line
  always_comb begin
    pickValid = 1'b0;
    pickSrc   = '0;
    if (nmiPend) begin
      pickValid = 1'b1;
    end else if (ieFlag) begin
      for (int i = MINT_N - 1; i >= 0; i--) begin
        if (!mintN[i]) begin
          pickValid = 1'b1;
          pickSrc   = SRC_W'(i + 1);
        end
      end
    end
  end

  always_comb begin
    strobe.take   = idle & insBound & ~busWin & pickValid;
    strobe.src    = pickSrc;
    strobe.haltGo = idle & insEnd & waitN & haltIns & ~halted &
                    ~(insBound & ~busWin & pickValid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= BUS_IDLE;
    end else begin
      case (state)
        BUS_IDLE:  if (busWin)  state <= BUS_GRANT;
        BUS_GRANT: if (busReqN) state <= BUS_IDLE;
        default:   state <= BUS_IDLE;
      endcase
    end
  end

  assign busAckN   = ~(state == BUS_GRANT);
  assign busOe     = idle;
  assign waitStall = ~waitN & idle;

  // R2
  grant_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busAckN) |-> $past(!busReqN));

  // R2
  release_next_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busAckN && busReqN) |=> busAckN);
endmodule

// File: rtl/rps_dp.sv
module rps_dp
  import rps_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             nmiN,
  input  logic             ieSet,
  input  logic             ieClr,
  input  logic             nmiRet,
  output logic             ieFlag,
  output logic             nmiPend,
  output logic             halted,
  output logic             ackValid,
  output logic [SRC_W-1:0] ackSrc,
  output logic             ackM1N,
  output logic             ackIorqN
);
  logic nmiPrev, ieSaved, takeNmi, takeLine0;

  assign takeNmi   = strobe.take & (strobe.src == '0);
  assign takeLine0 = strobe.take & (strobe.src == SRC_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev  <= 1'b1;
      nmiPend  <= 1'b0;
      ieFlag   <= 1'b0;
      ieSaved  <= 1'b0;
      halted   <= 1'b0;
      ackValid <= 1'b0;
      ackSrc   <= '0;
      ackM1N   <= 1'b1;
      ackIorqN <= 1'b1;
    end else begin
      nmiPrev <= nmiN;
      if (nmiPrev && !nmiN) nmiPend <= 1'b1;
      else if (takeNmi)     nmiPend <= 1'b0;

      if (strobe.take)  ieFlag <= 1'b0;
      else if (nmiRet)  ieFlag <= ieSaved;
      else if (ieSet)   ieFlag <= 1'b1;
      else if (ieClr)   ieFlag <= 1'b0;

      if (takeNmi) ieSaved <= ieFlag;

      if (strobe.take)        halted <= 1'b0;
      else if (strobe.haltGo) halted <= 1'b1;

      ackValid <= strobe.take;
      if (strobe.take) ackSrc <= strobe.src;
      ackM1N   <= ~takeLine0;
      ackIorqN <= ~takeLine0;
    end
  end

  // R4
  mask_needs_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackSrc != '0) |-> $past(ieFlag));

  // R4
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> !ieFlag);

  // R5
  upper_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackSrc > SRC_W'(1)) |-> (ackM1N && ackIorqN));

  // R6
  wake_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> ackValid);
endmodule

// File: rtl/req_priority_seq.sv
module req_priority_seq
  import rps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReqN,
  input  logic              nmiN,
  input  logic [MINT_N-1:0] mintN,
  input  logic              waitN,
  input  logic              mcEnd,
  input  logic              insEnd,
  input  logic              haltIns,
  input  logic              ieSet,
  input  logic              ieClr,
  input  logic              nmiRet,
  output logic              busAckN,
  output logic              busOe,
  output logic              haltN,
  output logic              waitStall,
  output logic              ackValid,
  output logic [SRC_W-1:0]  ackSrc,
  output logic              ackM1N,
  output logic              ackIorqN,
  output logic              ieFlag
);
  ctlStrobe_t strobe;
  logic nmiPend, halted;

  rps_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .mintN(mintN), .waitN(waitN),
    .mcEnd(mcEnd), .insEnd(insEnd), .haltIns(haltIns), .ieFlag(ieFlag),
    .nmiPend(nmiPend), .halted(halted), .strobe(strobe), .busAckN(busAckN),
    .busOe(busOe), .waitStall(waitStall)
  );

  rps_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nmiN(nmiN), .ieSet(ieSet),
    .ieClr(ieClr), .nmiRet(nmiRet), .ieFlag(ieFlag), .nmiPend(nmiPend),
    .halted(halted), .ackValid(ackValid), .ackSrc(ackSrc), .ackM1N(ackM1N),
    .ackIorqN(ackIorqN)
  );

  assign haltN = ~halted;

  // R10
  no_ack_while_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busAckN |-> !ackValid);
endmodule

// File: tb/test_req_priority_seq.sv
module test_req_priority_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReqN = 1'b1, nmiN = 1'b1, waitN = 1'b1;
  logic [2:0] mintN = 3'b111;
  logic mcEnd = 1'b0, insEnd = 1'b0, haltIns = 1'b0;
  logic ieSet = 1'b0, ieClr = 1'b0, nmiRet = 1'b0;
  logic busAckN, busOe, haltN, waitStall, ackValid, ackM1N, ackIorqN, ieFlag;
  logic [1:0] ackSrc;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  req_priority_seq i_req_priority_seq (
    .clk(clk), .rstN(rstN), .busReqN(busReqN), .nmiN(nmiN), .mintN(mintN),
    .waitN(waitN), .mcEnd(mcEnd), .insEnd(insEnd), .haltIns(haltIns),
    .ieSet(ieSet), .ieClr(ieClr), .nmiRet(nmiRet), .busAckN(busAckN),
    .busOe(busOe), .haltN(haltN), .waitStall(waitStall), .ackValid(ackValid),
    .ackSrc(ackSrc), .ackM1N(ackM1N), .ackIorqN(ackIorqN), .ieFlag(ieFlag)
  );

  // in: busReqN nmiN mintN[2:0] waitN mcEnd insEnd haltIns ieSet ieClr nmiRet
  // exp: busAckN haltN ackValid ackSrc[1:0] ackM1N ackIorqN ieFlag
  localparam int NV = 39;
  localparam logic [19:0] VEC [NV] = '{
    20'b1_1_111_1_0_0_0_1_0_0_1_1_0_00_1_1_1, // R4 enable
    20'b1_1_110_1_0_0_0_0_0_0_1_1_0_00_1_1_1, // R3 no boundary
    20'b1_1_110_1_1_0_0_0_0_0_1_1_0_00_1_1_1, // R3 machine boundary only
    20'b1_1_110_1_1_1_0_0_0_0_1_1_1_01_0_0_0, // R5 line 0 ack strobes
    20'b1_1_110_1_1_1_0_0_0_0_1_1_0_01_1_1_0, // R4 disabled after ack
    20'b1_1_011_1_0_0_0_1_0_0_1_1_0_01_1_1_1, // R4
    20'b1_1_001_1_1_1_0_0_0_0_1_1_1_10_1_1_0, // R1 line 1 over line 2
    20'b1_1_011_1_0_0_0_1_0_0_1_1_0_10_1_1_1, // R4
    20'b1_1_011_1_1_1_0_0_0_0_1_1_1_11_1_1_0, // R5 line 2
    20'b1_1_111_1_0_0_0_1_0_0_1_1_0_11_1_1_1, // R4
    20'b0_1_110_1_1_1_0_0_0_0_0_1_0_11_1_1_1, // R1 bus over line 0
    20'b0_1_110_1_1_1_0_0_0_0_0_1_0_11_1_1_1, // R10 frozen
    20'b1_1_110_1_0_0_0_0_0_0_1_1_0_11_1_1_1, // R2 release
    20'b1_1_110_1_1_1_0_0_0_0_1_1_1_01_0_0_0, // R5
    20'b0_1_111_1_0_0_0_0_0_0_1_1_0_01_1_1_0, // R2 no boundary
    20'b0_1_111_1_1_0_0_0_0_0_0_1_0_01_1_1_0, // R2 grant at mcEnd
    20'b1_1_111_1_0_0_0_0_0_0_1_1_0_01_1_1_0, // R2
    20'b1_0_111_1_0_0_0_0_0_0_1_1_0_01_1_1_0, // R8 edge latched
    20'b1_0_111_1_1_1_0_0_0_0_1_1_1_00_1_1_0, // R4 NMI with ie clear
    20'b1_0_111_1_1_1_0_0_0_0_1_1_0_00_1_1_0, // R8 held low
    20'b1_1_111_1_0_0_0_1_0_0_1_1_0_00_1_1_1, // R4
    20'b1_0_110_1_0_0_0_0_0_0_1_1_0_00_1_1_1, // R3
    20'b1_0_110_1_1_1_0_0_0_0_1_1_1_00_1_1_0, // R1 NMI over line 0
    20'b1_1_111_1_0_0_0_0_0_1_1_1_0_00_1_1_1, // R4 restore
    20'b1_1_111_1_0_0_0_0_1_0_1_1_0_00_1_1_0, // R4 clear
    20'b1_1_111_1_1_1_1_0_0_0_1_0_0_00_1_1_0, // R6 halt
    20'b1_1_110_1_0_0_0_0_0_0_1_0_0_00_1_1_0, // R6 masked no wake
    20'b0_1_111_1_0_0_0_0_0_0_0_0_0_00_1_1_0, // R6 grant while halted
    20'b1_1_111_1_0_0_0_0_0_0_1_0_0_00_1_1_0, // R6 still halted
    20'b1_1_111_1_0_0_0_1_0_0_1_0_0_00_1_1_1, // R6
    20'b1_1_101_1_0_0_0_0_0_0_1_1_1_10_1_1_0, // R6 wake by line 1
    20'b1_1_111_1_0_0_0_1_0_0_1_1_0_10_1_1_1, // R4
    20'b1_1_110_0_1_1_0_0_0_0_1_1_0_10_1_1_1, // R7 wait blocks ack
    20'b0_1_111_0_1_0_0_0_0_0_1_1_0_10_1_1_1, // R7 wait blocks grant
    20'b1_1_110_1_1_1_0_0_0_0_1_1_1_01_0_0_0, // R7
    20'b1_1_111_1_1_1_1_0_0_0_1_0_0_01_1_1_0, // R6
    20'b1_0_111_1_0_0_0_0_0_0_1_0_0_01_1_1_0, // R8
    20'b1_0_111_1_0_0_0_0_0_0_1_1_1_00_1_1_0, // R6 NMI wake
    20'b1_1_111_1_0_0_0_0_0_0_1_1_0_00_1_1_0  // R6
  };
  localparam int VREQ [NV] = '{4,3,3,5,4,4,1,4,5,4,1,10,2,5,2,2,2,8,4,8,
                                4,3,1,4,4,6,6,6,6,6,6,4,7,7,7,6,8,6,6};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {busAckN, haltN, ackValid, ackSrc, ackM1N, ackIorqN, ieFlag};
  endfunction

  task automatic drive(input logic [11:0] v);
    {busReqN, nmiN, mintN, waitN, mcEnd, insEnd, haltIns, ieSet, ieClr, nmiRet} = v;
  endtask

  localparam logic [11:0] IDLE_IN = 12'b1_1_111_1_0_0_0_0_0_0;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    check("R9", {outs()}, 8'b1_1_0_00_1_1_0);
    check("R9", {6'b0, busOe, waitStall}, 8'b0000_0010);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", outs(), 8'b1_1_0_00_1_1_0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][19:8]);
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VREQ[k], k), outs(), VEC[k][7:0]);
      check($sformatf("R2 busOe vec %0d", k), {7'b0, busOe}, {7'b0, VEC[k][7]});
    end

    // R7 combinational stall, and none while granted
    drive(IDLE_IN);
    waitN = 1'b0;
    #1 check("R7 stall", {7'b0, waitStall}, 8'd1);
    @(negedge clk);
    drive(IDLE_IN);
    busReqN = 1'b0; mcEnd = 1'b1;
    @(negedge clk);
    mcEnd = 1'b0; waitN = 1'b0;
    #1 check("R7 no stall when granted", {6'b0, busAckN, waitStall}, 8'd0);
    // R9 reset during grant
    rstN = 1'b0;
    #1 check("R9 reset in grant", {6'b0, busAckN, busOe}, 8'b0000_0011);
    @(negedge clk);
    drive(IDLE_IN);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after reset", outs(), 8'b1_1_0_00_1_1_0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule